// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the word a parallel NOR flash returns on reads while one of its internal program or erase algorithms is running. A controller pulses an operation start, naming the kind of operation, the most significant bit of the low byte being written, and the sector that is busy. It then pulses a done signal when the backend finishes. While the operation runs, every read returns a status word rather than array contents. A polling bit reports the inverse of the written bit for a program, or zero for an erase. A general toggle bit flips after every completed read. A sector toggle bit flips only for reads that hit the sector being erased.

Toggles advance on the falling edge of the read strobe and not with the clock. A read held over many cycles therefore returns one steady value, and software polling sees a flip from one read access to the next. Once the operation completes, reads pass through the backend's array data and the toggle state freezes. The next start pulse returns it to a known zero state.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `ready` is 1 and `rd_data` equals `array_data`.
- R2: `ready` is 0 from the first cycle after an `op_start` pulse until the `op_done` pulse. It is 1 again in the cycle after `op_done`. When `op_start` and `op_done` are high in the same cycle, the start wins and `ready` stays 0.
- R3: While a program operation runs (`op_is_erase`=0 at start), `rd_data[7]` reads the complement of the `prog_d7` value captured at start.
- R4: While an erase operation runs (`op_is_erase`=1 at start), `rd_data[7]` reads 0.
- R5: While busy, `rd_data[6]` inverts once for each completed read, where a read completes when `rd_en` goes from 1 to 0. A read held high for several cycles returns the same word on every cycle.
- R6: While an erase runs, `rd_data[2]` inverts on a completed read only if the read's sector (`rd_sector`, captured while `rd_en` is high) equals the busy sector `op_sector`. Reads of other sectors, and all reads during a program, leave `rd_data[2]` unchanged.
- R7: While busy, every `rd_data` bit other than bits 7, 6 and 2 reads 0.
- R8: When not busy, `rd_data` equals `array_data`. Reads made after completion do not change the toggle state.
- R9: An `op_start` pulse sets the toggle bits 6 and 2 to 0, even when it arrives while an operation is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | One-cycle pulse that begins an embedded operation |
| op_is_erase | input | 1 | Kind of operation at start: 1 erase, 0 program |
| prog_d7 | input | 1 | Bit 7 of the datum being programmed |
| op_sector | input | SECT_W | Sector being modified |
| op_done | input | 1 | One-cycle pulse when the backend finishes |
| rd_en | input | 1 | Read strobe, high for the length of a read access |
| rd_sector | input | SECT_W | Sector part of the read address |
| array_data | input | DATA_W | Array contents supplied by the backend |
| rd_data | output | DATA_W | Read data: status word while busy, array data otherwise |
| ready | output | 1 | 1 when idle, 0 while an operation runs |

## Verification
On every cycle the assertions check the ready timing around start and done pulses. They also check the polling bit against the operation kind captured at start, the zero filler bits, pass-through when idle, the cleared toggles right after a start, and the steadiness of a held read. Only the bench's scenarios show the toggle sequence itself. These cover flips counted per completed read and the sector toggle as the read sweeps every sector during an erase. They also show that the toggles stay frozen across reads made after completion.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
   // Bit positions inside the status word; readers decode these.
   localparam int POLL_BIT     = 7;
   localparam int TOG_BIT      = 6;
   localparam int SECT_TOG_BIT = 2;

   typedef struct packed {
      logic active;
      logic erase;
      logic poll_ref;
   } op_ctx_t;
endpackage

// File: rtl/fsg_rd_edge.sv
module fsg_rd_edge #(
   parameter int SECT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [SECT_W-1:0] rd_sector,
   output logic              rd_fall,
   output logic [SECT_W-1:0] last_sector
);
   logic rd_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_en_q     <= 1'b0;
         last_sector <= '0;
      end else begin
         rd_en_q <= rd_en;
         if (rd_en) last_sector <= rd_sector;
      end
   end

   // End of a read access: strobe was high, is now low.
   assign rd_fall = rd_en_q & ~rd_en;
endmodule

// File: rtl/fsg_op_ctrl.sv
module fsg_op_ctrl
   import fsg_pkg::*;
#(
   parameter int SECT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_is_erase,
   input  logic              prog_d7,
   input  logic [SECT_W-1:0] op_sector,
   input  logic              op_done,
   output op_ctx_t           ctx,
   output logic [SECT_W-1:0] busy_sector
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx         <= '0;
         busy_sector <= '0;
      end else if (op_start) begin
         ctx.active   <= 1'b1;
         ctx.erase    <= op_is_erase;
         ctx.poll_ref <= op_is_erase ? 1'b0 : ~prog_d7;
         busy_sector  <= op_sector;
      end else if (op_done) begin
         ctx.active <= 1'b0;
      end
   end
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle
   import fsg_pkg::*;
#(
   parameter int SECT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  op_ctx_t           ctx,
   input  logic              rd_fall,
   input  logic [SECT_W-1:0] last_sector,
   input  logic [SECT_W-1:0] busy_sector,
   output logic              tog_any,
   output logic              tog_sect
);
   logic hit;
   assign hit = ctx.erase && (last_sector == busy_sector);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_any  <= 1'b0;
         tog_sect <= 1'b0;
      end else if (clear) begin
         tog_any  <= 1'b0;
         tog_sect <= 1'b0;
      end else if (ctx.active && rd_fall) begin
         tog_any <= ~tog_any;
         if (hit) tog_sect <= ~tog_sect;
      end
   end
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
   import fsg_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              busy,
   input  logic              poll_ref,
   input  logic              tog_any,
   input  logic              tog_sect,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] status;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == POLL_BIT) begin : g_poll
         assign status[i] = poll_ref;
      end else if (i == TOG_BIT) begin : g_tog
         assign status[i] = tog_any;
      end else if (i == SECT_TOG_BIT) begin : g_sect
         assign status[i] = tog_sect;
      end else begin : g_zero
         assign status[i] = 1'b0;
      end
   end

   assign rd_data = busy ? status : array_data;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import fsg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SECT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic              op_is_erase,
   input  logic              prog_d7,
   input  logic [SECT_W-1:0] op_sector,
   input  logic              op_done,
   input  logic              rd_en,
   input  logic [SECT_W-1:0] rd_sector,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              ready
);
   if (DATA_W <= POLL_BIT) begin : g_bad_width
      $error("DATA_W must hold the polling bit");
   end
   if (SECT_W < 1) begin : g_bad_sect
      $error("SECT_W must be at least 1");
   end

   op_ctx_t           ctx;
   logic [SECT_W-1:0] busy_sector;
   logic [SECT_W-1:0] last_sector;
   logic              rd_fall;
   logic              tog_any;
   logic              tog_sect;

   fsg_op_ctrl #(.SECT_W(SECT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
      .prog_d7(prog_d7), .op_sector(op_sector), .op_done(op_done),
      .ctx(ctx), .busy_sector(busy_sector)
   );

   fsg_rd_edge #(.SECT_W(SECT_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sector(rd_sector),
      .rd_fall(rd_fall), .last_sector(last_sector)
   );

   fsg_toggle #(.SECT_W(SECT_W)) u_tog (
      .clk(clk), .rst_n(rst_n), .clear(op_start), .ctx(ctx), .rd_fall(rd_fall),
      .last_sector(last_sector), .busy_sector(busy_sector),
      .tog_any(tog_any), .tog_sect(tog_sect)
   );

   fsg_status_mux #(.DATA_W(DATA_W)) u_mux (
      .busy(ctx.active), .poll_ref(ctx.poll_ref), .tog_any(tog_any),
      .tog_sect(tog_sect), .array_data(array_data), .rd_data(rd_data)
   );

   assign ready = ~ctx.active;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
   import fsg_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SECT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_start,
   input logic              op_is_erase,
   input logic              prog_d7,
   input logic              op_done,
   input logic              rd_en,
   input logic [SECT_W-1:0] rd_sector,
   input logic [DATA_W-1:0] array_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              ready
);
   localparam logic [DATA_W-1:0] STAT_MASK =
      DATA_W'((1 << POLL_BIT) | (1 << TOG_BIT) | (1 << SECT_TOG_BIT));

   logic past_valid, c_erase, c_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_valid <= 1'b0;
         c_erase    <= 1'b0;
         c_ref      <= 1'b0;
      end else begin
         past_valid <= 1'b1;
         if (op_start) begin
            c_erase <= op_is_erase;
            c_ref   <= ~prog_d7;
         end
      end
   end

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past(op_start) |-> !ready); // R2
   AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past(op_done && !op_start) |-> ready); // R2
   AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !c_erase) |-> rd_data[POLL_BIT] == c_ref); // R3
   AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && c_erase) |-> !rd_data[POLL_BIT]); // R4
   AST_HELD_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && rd_en && $past(rd_en) && $stable(rd_sector) && !ready
      && $past(!ready) && !$past(op_start) |-> $stable(rd_data)); // R5
   AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (rd_data & ~STAT_MASK) == '0); // R7
   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> rd_data == array_data); // R8
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid && $past(op_start) |-> !rd_data[TOG_BIT] && !rd_data[SECT_TOG_BIT]); // R9
endmodule

bind flash_status_gen fsg_checker #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
   .prog_d7(prog_d7), .op_done(op_done), .rd_en(rd_en), .rd_sector(rd_sector),
   .array_data(array_data), .rd_data(rd_data), .ready(ready)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        op_start = 0, op_is_erase = 0, prog_d7 = 0, op_done = 0, rd_en = 0;
   logic [3:0]  op_sector = 0;
   logic [7:0]  rd_addr = 0;
   logic [15:0] array_data, rd_data;
   logic        ready;

   int checks = 0, errors = 0;
   bit m_busy = 0, m_erase = 0, m_ref = 0, e6 = 0, e2 = 0;
   logic [3:0] m_sect = 0;

   always #4 clk = ~clk;

   function automatic logic [15:0] arr(input logic [7:0] a);
      return {a, a ^ 8'hA5};
   endfunction
   assign array_data = arr(rd_addr);

   flash_status_gen uut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
      .prog_d7(prog_d7), .op_sector(op_sector), .op_done(op_done),
      .rd_en(rd_en), .rd_sector(rd_addr[7:4]), .array_data(array_data),
      .rd_data(rd_data), .ready(ready)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] expect_word(input logic [7:0] a);
      if (!m_busy) return arr(a);
      return 16'((m_ref << 7) | (e6 << 6) | (e2 << 2));
   endfunction

   task automatic rd(input logic [7:0] a, input string req, input int hold = 1);
      logic [15:0] e;
      @(negedge clk); rd_addr = a; rd_en = 1; #1;
      e = expect_word(a);
      chk(rd_data === e, req, rd_data, e);
      for (int i = 1; i < hold; i++) begin
         @(negedge clk); #1;
         chk(rd_data === e, "R5 held read", rd_data, e);
      end
      @(negedge clk); rd_en = 0;
      @(negedge clk);
      if (m_busy) begin
         e6 = ~e6;
         if (m_erase && a[7:4] == m_sect) e2 = ~e2;
      end
   endtask

   task automatic start(input bit er, input bit d7, input logic [3:0] s);
      @(negedge clk); op_start = 1; op_is_erase = er; prog_d7 = d7; op_sector = s;
      @(negedge clk); op_start = 0; #1;
      m_busy = 1; m_erase = er; m_ref = er ? 1'b0 : ~d7; m_sect = s; e6 = 0; e2 = 0;
      chk(ready === 1'b0, "R2 busy after start", 16'(ready), 16'h0);
   endtask

   task automatic finish_op;
      @(negedge clk); op_done = 1; #1;
      chk(ready === 1'b0, "R2 busy during done", 16'(ready), 16'h0);
      @(negedge clk); op_done = 0; #1;
      m_busy = 0;
      chk(ready === 1'b1, "R2 ready after done", 16'(ready), 16'h1);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      chk(ready === 1'b1, "R1 ready at reset", 16'(ready), 16'h1);
      chk(rd_data === arr(8'h00), "R1 pass-through at reset", rd_data, arr(8'h00));

      // Program operations with both polarities of bit 7 (R3, R5, R6 steady, R7, R8)
      for (int k = 0; k < 4; k++) begin
         start(1'b0, k[0], 4'(k));
         for (int r = 0; r < 5; r++) rd(8'(k * 16 + r * 37), "R3/R5/R6/R7 program read");
         finish_op();
         rd(8'h42, "R8 array after program");
         rd(8'h42, "R8 no toggle after done");
      end

      // Erase with a sweep of every read sector (R4, R6)
      for (int s = 0; s < 16; s += 5) begin
         start(1'b1, 1'b1, 4'(s));
         for (int q = 0; q < 16; q++) rd(8'({q[3:0], 4'h7}), "R4/R6 erase sweep");
         rd(8'({s[3:0], 4'h1}), "R6 in-sector", 4);
         rd(8'({s[3:0] ^ 4'h8, 4'h2}), "R6 out-of-sector", 3);
         finish_op();
         rd(8'h9C, "R8 array after erase");
      end

      // Restart while busy clears toggles (R9)
      start(1'b1, 1'b0, 4'h3);
      rd(8'h31, "R6 in-sector before restart");
      start(1'b0, 1'b1, 4'h5);
      rd(8'h50, "R9 toggles cleared by restart");

      // Start and done in the same cycle: start wins (R2)
      @(negedge clk); op_start = 1; op_done = 1; op_is_erase = 1; op_sector = 4'hA;
      @(negedge clk); op_start = 0; op_done = 0; #1;
      m_busy = 1; m_erase = 1; m_ref = 0; m_sect = 4'hA; e6 = 0; e2 = 0;
      chk(ready === 1'b0, "R2 start wins over done", 16'(ready), 16'h0);
      rd(8'hA0, "R4/R9 after start-with-done");
      finish_op();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule